// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a memory that two independent ports can reach at once. Each clock cycle it compares the two requests. It declares a collision only when both ports are enabled and both present the same address. It then picks one port to own the location. It raises a registered busy flag toward the other port and withholds that port's write permission, so the two ports never write one word at the same moment.

A static strap selects the role. As master, the block runs its own arbitration and drives the outcome on its busy outputs. Those outputs can be wired to the busy inputs of further devices that share the same requests, which widens the word. As slave, the block ignores its own result. It copies the busy inputs from the master to its busy outputs and holds off any write while the input busy for that port is high. In this way every slice of a wide word makes the same decision.

The interface is plain control signalling. There is no data stream, so there is no valid/ready handshake: enables, addresses and write requests are sampled level-wise every cycle.

Top module: `dp_contention_arbiter`

## Requirements
- R1: A collision exists only when `lft_en` and `rgt_en` are both 1 and `lft_addr` equals `rgt_addr`. With no collision and no busy still pending, an enabled port's write permission equals its write request.
- R2: In master mode (`is_master`=1), at most one busy output is high in any cycle, and during a collision exactly one port is the loser.
- R3: In master mode, the port whose request was already standing in the previous cycle (same enable and same address) wins over a port whose request is new. If both requests are new in the same cycle, or neither is, the left port wins.
- R4: A port that has won keeps the location for as long as its request stays unchanged, even when the other port arrives at the same address later.
- R5: In master mode, a busy output goes to 1 one cycle after the first colliding cycle. It returns to 0 one cycle after the collision ends.
- R6: A port's write permission is `en & wr & ~blocked`. In master mode, blocked is 1 from the first colliding cycle in which the port loses, and in every cycle in which its busy output is 1.
- R7: In slave mode (`is_master`=0), each busy output equals the matching external busy input in the same cycle. A write on that port is withheld while that input is 1, whatever the internal arbitration would decide.
- R8: In master mode, the external busy inputs have no effect on the busy outputs or on write permission.
- R9: While `rst_n` is 0, both busy outputs are 0 in master mode and any ownership is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | Role strap: 1 master, 0 slave (static) |
| lft_en | input | 1 | Left port enable |
| lft_addr | input | ADDR_W | Left port address |
| lft_wr | input | 1 | Left port write request |
| rgt_en | input | 1 | Right port enable |
| rgt_addr | input | ADDR_W | Right port address |
| rgt_wr | input | 1 | Right port write request |
| lft_busy_in | input | 1 | External busy for the left port (used in slave mode) |
| rgt_busy_in | input | 1 | External busy for the right port (used in slave mode) |
| lft_busy_out | output | 1 | Busy presented to the left port |
| rgt_busy_out | output | 1 | Busy presented to the right port |
| lft_wr_ok | output | 1 | Left write permitted this cycle |
| rgt_wr_ok | output | 1 | Right write permitted this cycle |

## Verification
The bench first targets the ordering rule. A late arrival at an address that is already held must lose, and a same-cycle tie must go to the left. A design that arbitrated on a fixed priority alone would hand the location to the left port while the right port was already writing it. The bench also checks the one-cycle lag of busy when a collision starts and when it ends. In those cycles a design that dropped the combinational loser gate would let two writes through together. A design that cleared busy too early would let the former loser write while the stale owner still held the location. In slave mode, the bench drives external busy values that contradict the internal tie rule. It also sets the external inputs during master mode, which exposes a design that mixes up the two sources.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int NPORT = 2;
  localparam int IDX_L = 0;
  localparam int IDX_R = 1;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              fresh
);
  logic              prev_en;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en   <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_en   <= en;
      prev_addr <= addr;
    end
  end

  // a request is new when it was not standing unchanged last cycle
  assign fresh = en & (~prev_en | (addr != prev_addr));
endmodule

// File: rtl/dpa_owner_arb.sv
module dpa_owner_arb
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_l,
  input  logic              en_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              fresh_l,
  input  logic              fresh_r,
  output logic              match,
  output owner_e            owner_d,
  output owner_e            owner_q
);
  assign match = en_l & en_r & (addr_l == addr_r);

  always_comb begin
    owner_d = OWN_NONE;
    if (match) begin
      if (owner_q == OWN_LEFT && !fresh_l)
        owner_d = OWN_LEFT;
      else if (owner_q == OWN_RIGHT && !fresh_r)
        owner_d = OWN_RIGHT;
      else if (fresh_l && !fresh_r)
        owner_d = OWN_RIGHT;
      else
        owner_d = OWN_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  AST_KEEP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_LEFT && match && !fresh_l) |=> owner_q == OWN_LEFT); // R4
  AST_KEEP_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_RIGHT && match && !fresh_r) |=> owner_q == OWN_RIGHT); // R4
  AST_OWNER_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> owner_q == OWN_NONE); // R1
  AST_OLD_BEATS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (match && owner_q == OWN_NONE && fresh_l && !fresh_r) |=> owner_q == OWN_RIGHT); // R3
endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate
  import dpa_pkg::*;
#(
  parameter int NP = NPORT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic          match,
  input  owner_e        owner_d,
  input  owner_e        owner_q,
  input  logic [NP-1:0] en,
  input  logic [NP-1:0] wr,
  input  logic [NP-1:0] busy_in,
  output logic [NP-1:0] busy_out,
  output logic [NP-1:0] wr_ok
);
  for (genvar i = 0; i < NP; i++) begin : g_port
    localparam owner_e WINNER_OTHER = (i == IDX_L) ? OWN_RIGHT : OWN_LEFT;
    logic lose_now;
    logic busy_q;
    logic blocked;

    assign lose_now    = match & (owner_d == WINNER_OTHER);
    assign busy_q      = (owner_q == WINNER_OTHER);
    assign busy_out[i] = is_master ? busy_q : busy_in[i];
    assign blocked     = is_master ? (lose_now | busy_q) : busy_in[i];
    assign wr_ok[i]    = en[i] & wr[i] & ~blocked;

    AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_master && busy_in[i]) |-> !wr_ok[i]); // R7
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_out[i] |-> !wr_ok[i]); // R6
  end
endmodule

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              lft_en,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic              lft_wr,
  input  logic              rgt_en,
  input  logic [ADDR_W-1:0] rgt_addr,
  input  logic              rgt_wr,
  input  logic              lft_busy_in,
  input  logic              rgt_busy_in,
  output logic              lft_busy_out,
  output logic              rgt_busy_out,
  output logic              lft_wr_ok,
  output logic              rgt_wr_ok
);
  logic [NPORT-1:0] en_v, wr_v, bin_v, bout_v, ok_v, fresh_v;
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic   match;
  owner_e owner_d, owner_q;

  assign en_v  = {rgt_en, lft_en};
  assign wr_v  = {rgt_wr, lft_wr};
  assign bin_v = {rgt_busy_in, lft_busy_in};
  assign addr_v[IDX_L] = lft_addr;
  assign addr_v[IDX_R] = rgt_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_track
    dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_v[p]),
      .addr  (addr_v[p]),
      .fresh (fresh_v[p])
    );
  end

  dpa_owner_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_l    (en_v[IDX_L]),
    .en_r    (en_v[IDX_R]),
    .addr_l  (addr_v[IDX_L]),
    .addr_r  (addr_v[IDX_R]),
    .fresh_l (fresh_v[IDX_L]),
    .fresh_r (fresh_v[IDX_R]),
    .match   (match),
    .owner_d (owner_d),
    .owner_q (owner_q)
  );

  dpa_write_gate #(.NP(NPORT)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_master (is_master),
    .match     (match),
    .owner_d   (owner_d),
    .owner_q   (owner_q),
    .en        (en_v),
    .wr        (wr_v),
    .busy_in   (bin_v),
    .busy_out  (bout_v),
    .wr_ok     (ok_v)
  );

  assign lft_busy_out = bout_v[IDX_L];
  assign rgt_busy_out = bout_v[IDX_R];
  assign lft_wr_ok    = ok_v[IDX_L];
  assign rgt_wr_ok    = ok_v[IDX_R];

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> !(lft_busy_out && rgt_busy_out)); // R2
  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && lft_en && rgt_en && lft_addr == rgt_addr) |-> !(lft_wr_ok && rgt_wr_ok)); // R2
  AST_BUSY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !(lft_en && rgt_en && lft_addr == rgt_addr))
      |=> (!is_master || (!lft_busy_out && !rgt_busy_out))); // R5
  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && $rose(rgt_busy_out)) |-> $past(lft_en && rgt_en && lft_addr == rgt_addr)); // R5
endmodule

// File: tb/dp_contention_arbiter_bench.sv
module dp_contention_arbiter_bench;
  localparam int AW = 15;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1;
  logic lft_en = 0, lft_wr = 0, rgt_en = 0, rgt_wr = 0;
  logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
  logic lft_busy_in = 0, rgt_busy_in = 0;
  logic lft_busy_out, rgt_busy_out, lft_wr_ok, rgt_wr_ok;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dp_contention_arbiter #(.ADDR_W(AW)) u_dp_contention_arbiter (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .lft_en(lft_en), .lft_addr(lft_addr), .lft_wr(lft_wr),
    .rgt_en(rgt_en), .rgt_addr(rgt_addr), .rgt_wr(rgt_wr),
    .lft_busy_in(lft_busy_in), .rgt_busy_in(rgt_busy_in),
    .lft_busy_out(lft_busy_out), .rgt_busy_out(rgt_busy_out),
    .lft_wr_ok(lft_wr_ok), .rgt_wr_ok(rgt_wr_ok)
  );

  // {l_en, l_addr[3:0], l_wr, r_en, r_addr[3:0], r_wr, l_bin, r_bin, exp{lb, rb, lok, rok}}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,4'd5,1'b1, 1'b0,4'd0,1'b0, 2'b00, 4'b0010}, // R1 left alone writes
    {1'b1,4'd5,1'b1, 1'b1,4'd5,1'b1, 2'b00, 4'b0010}, // R3 R6 late right loses at once
    {1'b1,4'd5,1'b1, 1'b1,4'd5,1'b1, 2'b00, 4'b0110}, // R5 R2 busy to right one cycle later
    {1'b0,4'd5,1'b1, 1'b1,4'd5,1'b1, 2'b00, 4'b0100}, // R5 R6 busy lingers one cycle
    {1'b0,4'd5,1'b1, 1'b1,4'd5,1'b1, 2'b00, 4'b0001}, // R5 busy cleared
    {1'b1,4'd5,1'b1, 1'b1,4'd5,1'b1, 2'b00, 4'b0001}, // R3 standing right wins over new left
    {1'b1,4'd5,1'b1, 1'b1,4'd5,1'b1, 2'b00, 4'b1001}, // R4 right keeps ownership
    {1'b1,4'd5,1'b1, 1'b1,4'd6,1'b1, 2'b00, 4'b1001}, // R5 R6 left still held off
    {1'b1,4'd9,1'b1, 1'b1,4'd9,1'b1, 2'b00, 4'b0010}, // R3 same-cycle tie to left
    {1'b1,4'd9,1'b1, 1'b1,4'd9,1'b1, 2'b11, 4'b0110}, // R8 external busy ignored
    {1'b1,4'd3,1'b1, 1'b1,4'd4,1'b1, 2'b00, 4'b0110}, // R1 R5 mismatch, stale busy
    {1'b1,4'd3,1'b1, 1'b1,4'd4,1'b1, 2'b00, 4'b0011}, // R1 mismatch, both write
    {1'b0,4'd4,1'b1, 1'b1,4'd4,1'b1, 2'b00, 4'b0001}  // R1 equal address, left disabled
  };

  task automatic check4(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s {lb,rb,lok,rok} actual=%b expected=%b", req, got, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check4("R9 reset state", {lft_busy_out, rgt_busy_out, lft_wr_ok, rgt_wr_ok}, 4'b0000);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      lft_en      = VEC[v][17];
      lft_addr    = AW'(VEC[v][16:13]);
      lft_wr      = VEC[v][12];
      rgt_en      = VEC[v][11];
      rgt_addr    = AW'(VEC[v][10:7]);
      rgt_wr      = VEC[v][6];
      lft_busy_in = VEC[v][5];
      rgt_busy_in = VEC[v][4];
      #5;
      check4($sformatf("R1/R2/R3/R4/R5/R6/R8 vector %0d", v),
             {lft_busy_out, rgt_busy_out, lft_wr_ok, rgt_wr_ok}, VEC[v][3:0]);
    end

    // R9: a collision held during reset raises no busy
    @(negedge clk);
    rst_n = 1'b0;
    lft_en = 1; rgt_en = 1; lft_addr = 7; rgt_addr = 7; lft_wr = 1; rgt_wr = 1;
    lft_busy_in = 0; rgt_busy_in = 0;
    repeat (2) @(posedge clk);
    #5;
    check4("R9 busy low in reset", {lft_busy_out, rgt_busy_out, 2'b00}, 4'b0000);

    // R7: slave mode adopts external result against the internal tie rule
    @(negedge clk);
    is_master = 1'b0;
    rst_n = 1'b1;
    lft_busy_in = 1; rgt_busy_in = 0;
    #5;
    check4("R7 slave left busy", {lft_busy_out, rgt_busy_out, lft_wr_ok, rgt_wr_ok}, 4'b1001);
    @(negedge clk);
    lft_busy_in = 0; rgt_busy_in = 1;
    #5;
    check4("R7 slave right busy", {lft_busy_out, rgt_busy_out, lft_wr_ok, rgt_wr_ok}, 4'b0110);
    @(negedge clk);
    rgt_busy_in = 0;
    #5;
    check4("R7 slave no external busy", {lft_busy_out, rgt_busy_out, lft_wr_ok, rgt_wr_ok}, 4'b0011);
    @(negedge clk);
    lft_wr = 0; lft_busy_in = 1;
    #5;
    check4("R6 no write without request", {lft_busy_out, rgt_busy_out, lft_wr_ok, rgt_wr_ok}, 4'b1001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule